// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a watchdog timer that sits on a simple single-cycle register bus. Software programs a 16-bit timeout compare value, chooses one of three counting sources and a power-of-four prescaler through a control register, and then enables counting. Each counting source is a tick-enable input that is synchronous to the bus clock.

Once enabled, a 16-bit up-counter advances once for every prescaled tick of the chosen source. When the counter reaches the compare value, the block raises `reset_req` for one bus-clock cycle. The counter then stops at that value. Software keeps the system alive by writing the counter back to zero before the match occurs. It stops the watchdog by clearing the enable register.

The intended reprogramming order is as follows: disable counting; write the prescaler with no source selected; load the compare value; clear the counter; write the control word again with the source bit set; enable counting.

Top module: `wdog_periph`

## Requirements
- R1: The four registers are decoded from `bus_addr[3:2]`: compare value at byte address 0x0, enable at 0x4 (only bit 0 is kept), counter at 0x8 and control at 0xC (bits 5:0 are kept). `bus_rdata` shows the addressed register, with unkept bits read as 0. An access whose `bus_addr[1:0]` is not 0 writes nothing and reads 0.
- R2: After reset every register reads 0, counting is off and `reset_req` is low.
- R3: In the control word, bit 0 selects `tick_pclk`, bit 1 selects `tick_rtc` and bit 2 selects `tick_ext` as the counting source. Ticks on sources that are not selected have no effect.
- R4: The counter advances only when enable is 1 and exactly one source bit is set. With no source bit, or with more than one, it holds its value.
- R5: Control bits 5:3 hold the prescaler code n. For codes 0 to 5 the counter advances once per 4^n selected ticks. Codes 6 and 7 divide by 1024.
- R6: When the enable is 1 and the counter equals the compare value, `reset_req` is high for exactly one cycle. This is the cycle after the equality first holds. `reset_req` is never high in the cycle after a cycle with the enable at 0.
- R7: While the enable is 1 and the counter equals the compare value, the counter holds. No further pulse occurs until the equality is broken and then restored.
- R8: A write to the counter loads the written data, so writing 0 is the keepalive. A counter write takes priority over a tick in the same cycle and restarts the prescaler phase.
- R9: A write to the control register restarts the prescaler phase. The next counter step then needs a full 4^n selected ticks.
- R10: Clearing the enable freezes the counter at its value. Setting it again resumes counting from that value.
- R11: A counter that is above the compare value keeps counting. It wraps from 0xFFFF to 0x0000 and can then reach the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this peripheral |
| bus_wr | input | 1 | Write qualifier; a write happens at the clock edge when both `bus_sel` and `bus_wr` are high |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, driven combinationally |
| tick_pclk | input | 1 | Tick enable of the peripheral clock source |
| tick_rtc | input | 1 | Tick enable of the low-frequency clock source |
| tick_ext | input | 1 | Tick enable of the external clock source |
| reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
A register write takes effect at the clock edge that samples it, and it can be read back on the falling edge that follows. A selected tick that completes a prescaler period moves the counter at the next edge. `reset_req` is registered, so it rises one edge after the counter takes the compare value. It falls one edge later.

The bench drives stimulus on falling edges. It counts every rising edge between a stimulus and the sample point, and samples on a falling edge. In the random phase, a cycle model in the bench advances on each rising edge. Both the read data and `reset_req` are compared with that model on every falling edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 16;
    localparam int CNT_W    = 16;
    localparam int NUM_SRC  = 3;
    localparam int PSC_W    = 3;
    localparam int MAX_CODE = 5;
    localparam int PRE_W    = 2 * MAX_CODE;
    localparam int CTRL_W   = NUM_SRC + PSC_W;

    typedef enum logic [1:0] {
        REG_CMP  = 2'd0,
        REG_EN   = 2'd1,
        REG_CNT  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic              en;
        logic [CTRL_W-1:0] ctrl;
    } cfg_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output cfg_t              cfg,
    output logic              cnt_wr,
    output logic              ctrl_wr,
    output logic              aligned
);

    cfg_t     cfg_d, cfg_q;
    reg_sel_e sel;
    logic     wr_en;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sel     = reg_sel_e'(bus_addr[ADDR_W-1:2]);
    assign wr_en   = bus_sel && bus_wr && aligned;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                REG_CMP:  cfg_d.cmp  = bus_wdata[CNT_W-1:0];
                REG_EN:   cfg_d.en   = bus_wdata[0];
                REG_CTRL: cfg_d.ctrl = bus_wdata[CTRL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg     = cfg_q;
    assign cnt_wr  = wr_en && (sel == REG_CNT);
    assign ctrl_wr = wr_en && (sel == REG_CTRL);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int NUM_SRC  = 3,
    parameter int PSC_W    = 3,
    parameter int MAX_CODE = 5,
    localparam int PRE_W   = 2 * MAX_CODE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [NUM_SRC-1:0] src_sel,
    input  logic [PSC_W-1:0]   code,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               clear,
    output logic               cnt_tick
);

    localparam logic [PSC_W-1:0] CODE_CAP = PSC_W'(MAX_CODE);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } psc_state_t;

    psc_state_t        st_d, st_q;
    logic [NUM_SRC-1:0] gated;
    logic              one_src;
    logic              sel_tick;
    logic [PSC_W-1:0]  eff_code;
    logic [PRE_W-1:0]  limit;
    logic              at_limit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign gated[i] = src_sel[i] & src_tick[i];
    end

    assign one_src  = (src_sel != '0) && ((src_sel & (src_sel - NUM_SRC'(1))) == '0);
    assign sel_tick = en && one_src && (|gated);
    assign eff_code = (code > CODE_CAP) ? CODE_CAP : code;
    assign limit    = ~({PRE_W{1'b1}} << {eff_code, 1'b0});
    assign at_limit = (st_q.pre == limit);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.pre = '0;
        end else if (sel_tick) begin
            st_d.pre = at_limit ? '0 : st_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_tick = sel_tick && at_limit && !clear;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cmp,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cnt_tick,
    output logic [CNT_W-1:0] cnt,
    output logic             reset_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       match;

    assign match = en && (st_q.cnt == cmp);

    always_comb begin
        st_d       = st_q;
        st_d.armed = match;
        st_d.req   = match && !st_q.armed;
        if (cnt_wr) begin
            st_d.cnt = cnt_wdata;
        end else if (cnt_tick && (st_q.cnt != cmp)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign reset_req = st_q.req;

endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_pclk,
    input  logic              tick_rtc,
    input  logic              tick_ext,
    output logic              reset_req
);

    cfg_t               cfg;
    logic               cnt_wr_w;
    logic               ctrl_wr_w;
    logic               aligned;
    logic               cnt_tick;
    logic               en_w;
    logic [CNT_W-1:0]   cmp_w;
    logic [CNT_W-1:0]   cnt_w;
    logic [NUM_SRC-1:0] src_w;
    logic [CNT_W-1:0]   wdata_w;

    assign en_w    = cfg.en;
    assign cmp_w   = cfg.cmp;
    assign src_w   = cfg.ctrl[NUM_SRC-1:0];
    assign wdata_w = bus_wdata[CNT_W-1:0];

    wdog_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg       (cfg),
        .cnt_wr    (cnt_wr_w),
        .ctrl_wr   (ctrl_wr_w),
        .aligned   (aligned)
    );

    wdog_prescaler #(
        .NUM_SRC  (NUM_SRC),
        .PSC_W    (PSC_W),
        .MAX_CODE (MAX_CODE)
    ) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .src_sel  (src_w),
        .code     (cfg.ctrl[CTRL_W-1:NUM_SRC]),
        .src_tick ({tick_ext, tick_rtc, tick_pclk}),
        .clear    (ctrl_wr_w || cnt_wr_w),
        .cnt_tick (cnt_tick)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_w),
        .cmp       (cmp_w),
        .cnt_wr    (cnt_wr_w),
        .cnt_wdata (wdata_w),
        .cnt_tick  (cnt_tick),
        .cnt       (cnt_w),
        .reset_req (reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (reg_sel_e'(bus_addr[ADDR_W-1:2]))
                REG_CMP:  bus_rdata = DATA_W'(cmp_w);
                REG_EN:   bus_rdata = DATA_W'(en_w);
                REG_CNT:  bus_rdata = DATA_W'(cnt_w);
                REG_CTRL: bus_rdata = DATA_W'(cfg.ctrl);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_periph_chk.sv
module wdog_periph_chk #(
    parameter int CNT_W   = 16,
    parameter int NUM_SRC = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [NUM_SRC-1:0] src_sel,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   cmp,
    input logic               cnt_wr,
    input logic [CNT_W-1:0]   cnt_wdata,
    input logic               reset_req
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R6

    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !reset_req); // R6

    AST_REQ_FOLLOWS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> ($past(en) && ($past(cnt) == $past(cmp)))); // R6

    AST_HOLD_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (cnt == cmp) && !cnt_wr) |=> $stable(cnt)); // R7

    AST_NO_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$onehot(src_sel) && !cnt_wr) |=> $stable(cnt)); // R4

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt)); // R10

    AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + CNT_W'(1))))); // R11

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata))); // R8

endmodule

bind wdog_periph wdog_periph_chk #(
    .CNT_W   (wdog_pkg::CNT_W),
    .NUM_SRC (wdog_pkg::NUM_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_w),
    .src_sel   (src_w),
    .cnt       (cnt_w),
    .cmp       (cmp_w),
    .cnt_wr    (cnt_wr_w),
    .cnt_wdata (wdata_w),
    .reset_req (reset_req)
);

// File: tb/tb_wdog_periph.sv
`timescale 1ns/1ps
module tb_wdog_periph;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_pclk = 1'b0;
    logic        tick_rtc = 1'b0;
    logic        tick_ext = 1'b0;
    logic        reset_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    wdog_periph dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_pclk (tick_pclk),
        .tick_rtc  (tick_rtc),
        .tick_ext  (tick_ext),
        .reset_req (reset_req)
    );

    // Reference model built from the requirements
    logic [15:0] m_cmp, m_cnt;
    logic        m_en, m_armed, m_req;
    logic [5:0]  m_ctrl;
    logic [9:0]  m_pre;

    function automatic logic [9:0] div_limit(input logic [2:0] code);
        int e;
        e = (code > 3'd5) ? 5 : int'(code);
        return 10'((1 << (2 * e)) - 1);
    endfunction

    function automatic logic [15:0] model_read(input logic [3:0] a);
        if (a[1:0] != 2'b00) return 16'h0000;
        case (a[3:2])
            2'd0:    return m_cmp;
            2'd1:    return {15'd0, m_en};
            2'd2:    return m_cnt;
            default: return {10'd0, m_ctrl};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        logic       wr, clr, one, stick, adv, matchv;
        logic [1:0] a;
        logic [2:0] srcs;
        logic [9:0] lim;
        if (!rst_n) begin
            m_cmp = '0; m_cnt = '0; m_en = 1'b0; m_armed = 1'b0;
            m_req = 1'b0; m_ctrl = '0; m_pre = '0;
        end else begin
            wr     = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
            a      = bus_addr[3:2];
            srcs   = m_ctrl[2:0];
            one    = (srcs == 3'b001) || (srcs == 3'b010) || (srcs == 3'b100);
            stick  = m_en && one && ((srcs & {tick_ext, tick_rtc, tick_pclk}) != 3'b000);
            lim    = div_limit(m_ctrl[5:3]);
            clr    = wr && (a == 2'd2 || a == 2'd3);
            adv    = stick && (m_pre == lim) && !clr;
            matchv = m_en && (m_cnt == m_cmp);
            m_req   = matchv && !m_armed;
            m_armed = matchv;
            if (clr)        m_pre = '0;
            else if (stick) m_pre = (m_pre == lim) ? 10'd0 : m_pre + 10'd1;
            if (wr && a == 2'd2)              m_cnt = bus_wdata;
            else if (adv && m_cnt != m_cmp)   m_cnt = m_cnt + 16'd1;
            if (wr && a == 2'd0) m_cmp  = bus_wdata;
            if (wr && a == 2'd1) m_en   = bus_wdata[0];
            if (wr && a == 2'd3) m_ctrl = bus_wdata[5:0];
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    // Called on a falling edge; returns on the falling edge after the write edge.
    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [15:0] exp, input string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input logic [15:0] cmp, input logic [5:0] ctrl);
        bus_write(4'h4, 16'h0000);
        bus_write(4'hC, {10'd0, ctrl & 6'h38});
        bus_write(4'h0, cmp);
        bus_write(4'h8, 16'h0000);
        bus_write(4'hC, {10'd0, ctrl});
        bus_write(4'h4, 16'h0001);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        read_chk(4'h0, 16'h0000, "R2");
        read_chk(4'h4, 16'h0000, "R2");
        read_chk(4'h8, 16'h0000, "R2");
        read_chk(4'hC, 16'h0000, "R2");
        check("R2", {15'd0, reset_req}, 16'h0000);

        // R1 register map and readback
        tick_pclk = 1'b1; tick_rtc = 1'b1; tick_ext = 1'b1;
        bus_write(4'h0, 16'hBEEF);
        read_chk(4'h0, 16'hBEEF, "R1");
        bus_write(4'hC, 16'hFFFF);
        read_chk(4'hC, 16'h003F, "R1");
        bus_write(4'h4, 16'h00FF);
        read_chk(4'h4, 16'h0001, "R1");
        bus_write(4'h4, 16'h0000);
        bus_write(4'h8, 16'h1234);
        read_chk(4'h8, 16'h1234, "R1");
        bus_write(4'h1, 16'h7777);
        read_chk(4'h0, 16'hBEEF, "R1");
        read_chk(4'h1, 16'h0000, "R1");

        // R6/R7 timeout pulse, divide by 1 on the peripheral source
        configure(16'd5, 6'h01);
        wait_edges(3);
        read_chk(4'h8, 16'd3, "R4");
        wait_edges(2);
        read_chk(4'h8, 16'd5, "R6");
        check("R6", {15'd0, reset_req}, 16'h0000);
        wait_edges(1);
        check("R6", {15'd0, reset_req}, 16'h0001);
        wait_edges(1);
        check("R6", {15'd0, reset_req}, 16'h0000);
        wait_edges(3);
        read_chk(4'h8, 16'd5, "R7");
        check("R7", {15'd0, reset_req}, 16'h0000);

        // R8 keepalive and write priority
        bus_write(4'h8, 16'h0000);
        read_chk(4'h8, 16'd0, "R8");
        wait_edges(2);
        read_chk(4'h8, 16'd2, "R8");
        bus_write(4'h8, 16'h0100);
        read_chk(4'h8, 16'h0100, "R8");
        wait_edges(1);
        read_chk(4'h8, 16'h0101, "R11");

        // R4 no source and two sources
        bus_write(4'hC, 16'h0000);
        bus_write(4'h8, 16'd3);
        wait_edges(5);
        read_chk(4'h8, 16'd3, "R4");
        bus_write(4'hC, 16'h0003);
        wait_edges(5);
        read_chk(4'h8, 16'd3, "R4");

        // R3 source selection
        tick_pclk = 1'b1; tick_rtc = 1'b0; tick_ext = 1'b1;
        bus_write(4'hC, 16'h0002);
        bus_write(4'h8, 16'd0);
        wait_edges(4);
        read_chk(4'h8, 16'd0, "R3");
        tick_rtc = 1'b1;
        wait_edges(3);
        read_chk(4'h8, 16'd3, "R3");
        tick_pclk = 1'b0; tick_rtc = 1'b0; tick_ext = 1'b1;
        bus_write(4'hC, 16'h0004);
        bus_write(4'h8, 16'd0);
        wait_edges(2);
        read_chk(4'h8, 16'd2, "R3");
        tick_pclk = 1'b1; tick_rtc = 1'b1;

        // R5 divide by 4
        configure(16'd100, 6'h09);
        wait_edges(3);
        read_chk(4'h8, 16'd0, "R5");
        wait_edges(1);
        read_chk(4'h8, 16'd1, "R5");
        wait_edges(4);
        read_chk(4'h8, 16'd2, "R5");

        // R9 control write restarts the prescaler phase
        wait_edges(2);
        bus_write(4'hC, 16'h0009);
        wait_edges(3);
        read_chk(4'h8, 16'd2, "R9");
        wait_edges(1);
        read_chk(4'h8, 16'd3, "R9");

        // R5 code 7 behaves as divide by 1024
        bus_write(4'hC, 16'h0039);
        bus_write(4'h8, 16'd0);
        wait_edges(1023);
        read_chk(4'h8, 16'd0, "R5");
        wait_edges(1);
        read_chk(4'h8, 16'd1, "R5");

        // R10 disable freezes, enable resumes
        bus_write(4'hC, 16'h0001);
        bus_write(4'h8, 16'd10);
        wait_edges(2);
        read_chk(4'h8, 16'd12, "R10");
        bus_write(4'h4, 16'h0000);
        read_chk(4'h8, 16'd13, "R10");
        wait_edges(5);
        read_chk(4'h8, 16'd13, "R10");
        bus_write(4'h4, 16'h0001);
        read_chk(4'h8, 16'd13, "R10");
        wait_edges(2);
        read_chk(4'h8, 16'd15, "R10");

        // R11 wrap through 0xFFFF to reach the compare value
        bus_write(4'h0, 16'd2);
        bus_write(4'h8, 16'hFFFE);
        read_chk(4'h8, 16'hFFFE, "R11");
        wait_edges(2);
        read_chk(4'h8, 16'h0000, "R11");
        wait_edges(2);
        read_chk(4'h8, 16'd2, "R11");
        check("R6", {15'd0, reset_req}, 16'h0000);
        wait_edges(1);
        check("R6", {15'd0, reset_req}, 16'h0001);
        wait_edges(1);
        check("R6", {15'd0, reset_req}, 16'h0000);

        // Random phase compared against the model
        for (int i = 0; i < 4000; i++) begin
            check("R1", bus_rdata, model_read(bus_addr));
            check("R6", {15'd0, reset_req}, {15'd0, m_req});
            bus_addr  = {$urandom_range(0, 3) == 0 ? 2'($urandom_range(0, 3)) : 2'($urandom_range(0, 3)),
                         ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00};
            bus_sel   = ($urandom_range(0, 7) == 0);
            bus_wr    = bus_sel;
            case (bus_addr[3:2])
                2'd0:    bus_wdata = 16'($urandom_range(0, 30));
                2'd1:    bus_wdata = ($urandom_range(0, 3) != 0) ? 16'h0001 : 16'h0000;
                2'd2:    bus_wdata = ($urandom_range(0, 1) != 0) ? 16'h0000 : 16'($urandom_range(0, 40));
                default: begin
                    if ($urandom_range(0, 3) != 0)
                        bus_wdata = {10'd0, 3'($urandom_range(0, 2)), 3'(1 << $urandom_range(0, 2))};
                    else
                        bus_wdata = 16'($urandom);
                end
            endcase
            tick_pclk = 1'($urandom);
            tick_rtc  = 1'($urandom);
            tick_ext  = 1'($urandom);
            @(negedge clk);
        end

        bus_sel = 1'b0; bus_wr = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule